// File: doc/BRIEF.md
# Address Quadrant Context Selector

This unit sits in front of a radix-style address translator and classifies every effective address before any table is read. The two most significant address bits pick one of four quadrants. The quadrant and the hypervisor-state bit together choose the partition identifier and the process identifier that the later walk uses. In guest state, two of the quadrants are forbidden. An access to either one ends in a segment-type fault instead of a context.

The unit also settles hypervisor real-mode accesses. These are accesses made in hypervisor state while relocation is off for that access type. For them it forms the real address directly and grants full permission, so no walk is started.

Each request is a single-cycle pulse. The answer arrives one cycle later, as one of two registered outputs: a response strobe that carries the context or the real address, or a fault strobe that names the interrupt class. For data faults, the faulting address is captured into a held register.

Top module: `addr_ctx_sel`

## Requirements
- R1: After synchronous reset, `rsp_valid`, `rsp_fault`, `seg_inst`, `seg_data` are 0 and `fault_dar` is 0.
- R2: A request accepted on a clock edge (`req_valid`=1) produces, on the next cycle only, exactly one of `rsp_valid` or `rsp_fault`. A cycle without a request produces neither.
- R3: Relocation for an access comes from `ir_en` when `req_kind[1]`=1 (instruction fetch) and from `dr_en` otherwise (`req_kind` 2'b00 load, 2'b01 store).
- R4: In hypervisor state with relocation on, the quadrant `req_ea[63:62]` selects the identifier pair (partition, process): 0 gives (0, `pid_reg`), 1 gives (`lpid_reg`, `pid_reg`), 2 gives (`lpid_reg`, 0), 3 gives (0, 0).
- R5: In guest state (`hv_mode`=0), quadrant 0 gives (`lpid_reg`, `pid_reg`) and quadrant 3 gives (`lpid_reg`, 0), whatever the relocation bits are.
- R6: In guest state, quadrants 1 and 2 raise `rsp_fault` and never `rsp_valid`.
- R7: On a fault, a fetch sets `seg_inst` only. A load or store sets `seg_data` only and loads `req_ea` into `fault_dar`.
- R8: `fault_dar` keeps its value across every outcome other than a data segment fault.
- R9: In hypervisor state with relocation off, `rsp_real`=1 and `rsp_addr` is `req_ea` with bits [63:60] cleared, ORed with `hrmor_reg` when `req_ea[63]`=0. `rsp_perm` is 3'b111 ({read, write, execute}) and both identifiers are 0.
- R10: On the translate path, `rsp_real`=0, `rsp_addr` equals `req_ea` and `rsp_perm` is 3'b000. `rsp_quadrant` always reports `req_ea[63:62]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ea | input | EA_W | Effective address |
| req_kind | input | 2 | 00 load, 01 store, 1x fetch |
| hv_mode | input | 1 | Hypervisor state |
| ir_en | input | 1 | Instruction relocation enable |
| dr_en | input | 1 | Data relocation enable |
| lpid_reg | input | LPID_W | Partition identifier register |
| pid_reg | input | PID_W | Process identifier register |
| hrmor_reg | input | EA_W | Hypervisor real-mode offset |
| rsp_valid | output | 1 | Context or real address ready |
| rsp_fault | output | 1 | Segment fault strobe |
| rsp_real | output | 1 | Result is a real-mode address |
| rsp_quadrant | output | 2 | Decoded quadrant |
| rsp_lpid | output | LPID_W | Selected partition identifier |
| rsp_pid | output | PID_W | Selected process identifier |
| rsp_addr | output | EA_W | Real address or pass-through effective address |
| rsp_perm | output | 3 | Granted {read, write, execute} |
| seg_inst | output | 1 | Instruction segment fault |
| seg_data | output | 1 | Data segment fault |
| fault_dar | output | EA_W | Captured data fault address |

## Verification
The assertions assume that the state bits and the identifier registers are steady during the cycle in which a request is sampled. They also assume that `req_kind` never carries a value the requirements leave open. The bench drives every input once per request, half a cycle before the sampling edge, and holds it there. It uses only the three defined access kinds. It also follows every request with an idle cycle, so that the no-request and hold properties are exercised between responses.

// File: rtl/addr_ctx_pkg.sv
package addr_ctx_pkg;
  typedef enum logic [1:0] {
    QUAD_USER  = 2'd0,
    QUAD_GUEST = 2'd1,
    QUAD_HOSTP = 2'd2,
    QUAD_KERN  = 2'd3
  } quad_e;

  localparam logic [2:0] PERM_ALL  = 3'b111;
  localparam logic [2:0] PERM_NONE = 3'b000;

  function automatic logic kind_is_fetch(input logic [1:0] kind);
    return kind[1];
  endfunction
endpackage

// File: rtl/ctx_quadrant_decode.sv
module ctx_quadrant_decode
  import addr_ctx_pkg::*;
#(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic [1:0]        ea_top,
  input  logic              hv,
  input  logic [LPID_W-1:0] lpid_in,
  input  logic [PID_W-1:0]  pid_in,
  output quad_e             quad,
  output logic [LPID_W-1:0] lpid_sel,
  output logic [PID_W-1:0]  pid_sel,
  output logic              illegal
);
  always_comb begin
    quad     = quad_e'(ea_top);
    lpid_sel = '0;
    pid_sel  = '0;
    illegal  = 1'b0;
    if (hv) begin
      unique case (quad)
        QUAD_USER:  pid_sel = pid_in;
        QUAD_GUEST: begin lpid_sel = lpid_in; pid_sel = pid_in; end
        QUAD_HOSTP: lpid_sel = lpid_in;
        QUAD_KERN:  ;
      endcase
    end else begin
      unique case (quad)
        QUAD_USER:  begin lpid_sel = lpid_in; pid_sel = pid_in; end
        QUAD_GUEST, QUAD_HOSTP: illegal = 1'b1;
        QUAD_KERN:  lpid_sel = lpid_in;
      endcase
    end
  end
endmodule

// File: rtl/ctx_realmode_form.sv
module ctx_realmode_form #(
  parameter int EA_W     = 64,
  parameter int CLR_BITS = 4
) (
  input  logic [EA_W-1:0] ea,
  input  logic [EA_W-1:0] offset,
  output logic [EA_W-1:0] raddr
);
  localparam int KEEP_W = EA_W - CLR_BITS;
  localparam logic [EA_W-1:0] KEEP_MASK = {{CLR_BITS{1'b0}}, {KEEP_W{1'b1}}};

  always_comb begin
    raddr = ea & KEEP_MASK;
    if (!ea[EA_W-1]) raddr = raddr | offset;
  end
endmodule

// File: rtl/ctx_fault_route.sv
module ctx_fault_route (
  input  logic fire,
  input  logic is_fetch,
  output logic to_inst,
  output logic to_data
);
  always_comb begin
    to_inst = fire && is_fetch;
    to_data = fire && !is_fetch;
  end
endmodule

// File: rtl/addr_ctx_sel.sv
module addr_ctx_sel
  import addr_ctx_pkg::*;
#(
  parameter int EA_W     = 64,
  parameter int LPID_W   = 12,
  parameter int PID_W    = 20,
  parameter int CLR_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [1:0]        req_kind,
  input  logic              hv_mode,
  input  logic              ir_en,
  input  logic              dr_en,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  input  logic [EA_W-1:0]   hrmor_reg,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_real,
  output logic [1:0]        rsp_quadrant,
  output logic [LPID_W-1:0] rsp_lpid,
  output logic [PID_W-1:0]  rsp_pid,
  output logic [EA_W-1:0]   rsp_addr,
  output logic [2:0]        rsp_perm,
  output logic              seg_inst,
  output logic              seg_data,
  output logic [EA_W-1:0]   fault_dar
);
  localparam int QHI = EA_W - 1;
  localparam int QLO = EA_W - 2;

  logic              fetch_acc;
  logic              reloc;
  logic              real_path;
  quad_e             quad;
  logic [LPID_W-1:0] lpid_sel;
  logic [PID_W-1:0]  pid_sel;
  logic              illegal;
  logic [EA_W-1:0]   real_addr;
  logic              flt_inst;
  logic              flt_data;

  always_comb begin
    fetch_acc = kind_is_fetch(req_kind);
    reloc     = fetch_acc ? ir_en : dr_en;
    real_path = hv_mode && !reloc;
  end

  ctx_quadrant_decode #(.LPID_W(LPID_W), .PID_W(PID_W)) u_quad (
    .ea_top   (req_ea[QHI:QLO]),
    .hv       (hv_mode),
    .lpid_in  (lpid_reg),
    .pid_in   (pid_reg),
    .quad     (quad),
    .lpid_sel (lpid_sel),
    .pid_sel  (pid_sel),
    .illegal  (illegal)
  );

  ctx_realmode_form #(.EA_W(EA_W), .CLR_BITS(CLR_BITS)) u_real (
    .ea     (req_ea),
    .offset (hrmor_reg),
    .raddr  (real_addr)
  );

  ctx_fault_route u_route (
    .fire     (req_valid && illegal),
    .is_fetch (fetch_acc),
    .to_inst  (flt_inst),
    .to_data  (flt_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_real     <= 1'b0;
      rsp_quadrant <= '0;
      rsp_lpid     <= '0;
      rsp_pid      <= '0;
      rsp_addr     <= '0;
      rsp_perm     <= PERM_NONE;
      seg_inst     <= 1'b0;
      seg_data     <= 1'b0;
      fault_dar    <= '0;
    end else begin
      rsp_valid <= req_valid && !illegal;
      rsp_fault <= req_valid && illegal;
      seg_inst  <= flt_inst;
      seg_data  <= flt_data;
      if (flt_data) fault_dar <= req_ea;
      if (req_valid) begin
        rsp_quadrant <= quad;
        rsp_real     <= real_path;
        if (real_path) begin
          rsp_lpid <= '0;
          rsp_pid  <= '0;
          rsp_addr <= real_addr;
          rsp_perm <= PERM_ALL;
        end else begin
          rsp_lpid <= lpid_sel;
          rsp_pid  <= pid_sel;
          rsp_addr <= req_ea;
          rsp_perm <= PERM_NONE;
        end
      end
    end
  end

  a_r2_single_outcome: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_fault));
  a_r2_answer_next: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_valid || rsp_fault));
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_fault));
  a_r6_guest_forbidden: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hv_mode && (req_ea[QHI] != req_ea[QLO])) |=> rsp_fault);
  a_r7_one_class: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> ($countones({seg_inst, seg_data}) == 1));
  a_r8_dar_hold: assert property (@(posedge clk) disable iff (rst)
    !seg_data |-> $stable(fault_dar));
  a_r9_real_perm: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_real) |-> (rsp_perm == PERM_ALL));
  a_r10_xlate_perm: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_real) |-> (rsp_perm == PERM_NONE));
endmodule

// File: tb/addr_ctx_sel_tb.sv
module addr_ctx_sel_tb_top;
  localparam int EA_W = 64;
  localparam int LPID_W = 12;
  localparam int PID_W = 20;
  localparam logic [LPID_W-1:0] LPID_V = 12'hA5C;
  localparam logic [PID_W-1:0]  PID_V  = 20'h3_1F2E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [EA_W-1:0] req_ea = '0;
  logic [1:0] req_kind = 2'b00;
  logic hv_mode = 1'b0, ir_en = 1'b0, dr_en = 1'b0;
  logic [LPID_W-1:0] lpid_reg = LPID_V;
  logic [PID_W-1:0] pid_reg = PID_V;
  logic [EA_W-1:0] hrmor_reg = '0;
  logic rsp_valid, rsp_fault, rsp_real, seg_inst, seg_data;
  logic [1:0] rsp_quadrant;
  logic [LPID_W-1:0] rsp_lpid;
  logic [PID_W-1:0] rsp_pid;
  logic [EA_W-1:0] rsp_addr, fault_dar;
  logic [2:0] rsp_perm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addr_ctx_sel dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea),
    .req_kind(req_kind), .hv_mode(hv_mode), .ir_en(ir_en), .dr_en(dr_en),
    .lpid_reg(lpid_reg), .pid_reg(pid_reg), .hrmor_reg(hrmor_reg),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_real(rsp_real),
    .rsp_quadrant(rsp_quadrant), .rsp_lpid(rsp_lpid), .rsp_pid(rsp_pid),
    .rsp_addr(rsp_addr), .rsp_perm(rsp_perm), .seg_inst(seg_inst),
    .seg_data(seg_data), .fault_dar(fault_dar)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [EA_W-1:0] exp_dar;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && rsp_fault == 0, "R1 strobes", {62'd0, rsp_valid, rsp_fault}, 0);
    chk(seg_inst == 0 && seg_data == 0, "R1 seg", {62'd0, seg_inst, seg_data}, 0);
    chk(fault_dar == 0, "R1 dar", fault_dar, 0);
    rst = 1'b0;
    exp_dar = '0;
    @(negedge clk);
    chk(rsp_valid == 0 && rsp_fault == 0, "R2 idle after reset", {62'd0, rsp_valid, rsp_fault}, 0);
    for (int c = 0; c < 192; c++) begin
      logic hv, ir, dr, fetch, reloc, realm, bad;
      logic [1:0] kind, q;
      logic [EA_W-1:0] ea, ex_addr;
      logic [LPID_W-1:0] ex_l;
      logic [PID_W-1:0] ex_p;
      hv = c[0]; ir = c[1]; dr = c[2];
      kind = 2'(c[4:3] % 3);
      q = c[6:5];
      ea = {q, 62'h0} | (c[7] ? 64'h2ABC_DEF0_1234_5678 : 64'h1000_0000_0000_0F0F);
      ea = ea ^ {56'd0, 8'(c)};
      hrmor_reg = 64'h0000_0040_0000_0000 << (c % 5);
      fetch = kind[1];
      reloc = fetch ? ir : dr;
      realm = hv && !reloc;
      bad = !realm && !hv && (q == 2'd1 || q == 2'd2);
      ex_l = '0; ex_p = '0;
      if (realm) begin
        ex_addr = (ea & 64'h0FFF_FFFF_FFFF_FFFF) | (ea[63] ? 64'd0 : hrmor_reg);
      end else begin
        ex_addr = ea;
        if (hv) begin
          if (q == 1 || q == 2) ex_l = LPID_V;
          if (q == 0 || q == 1) ex_p = PID_V;
        end else begin
          ex_l = LPID_V;
          if (q == 0) ex_p = PID_V;
        end
      end
      req_ea = ea; req_kind = kind; hv_mode = hv; ir_en = ir; dr_en = dr;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (bad) begin
        chk(rsp_fault == 1 && rsp_valid == 0, "R6 guest forbidden quadrant",
            {62'd0, rsp_fault, rsp_valid}, 64'd2);
        chk(seg_inst == fetch && seg_data == !fetch, "R7 fault class",
            {62'd0, seg_inst, seg_data}, {62'd0, fetch, !fetch});
        if (!fetch) exp_dar = ea;
        chk(fault_dar == exp_dar, "R7 R8 fault_dar", fault_dar, exp_dar);
      end else begin
        chk(rsp_valid == 1 && rsp_fault == 0, "R2 R3 response strobe",
            {62'd0, rsp_valid, rsp_fault}, 64'd2);
        chk(rsp_real == realm, "R3 relocation select", {63'd0, rsp_real}, {63'd0, realm});
        chk(rsp_addr == ex_addr, realm ? "R9 real address" : "R10 pass address",
            rsp_addr, ex_addr);
        chk(rsp_perm == (realm ? 3'b111 : 3'b000), realm ? "R9 perm" : "R10 perm",
            {61'd0, rsp_perm}, realm ? 64'd7 : 64'd0);
        chk(rsp_lpid == ex_l && rsp_pid == ex_p, hv ? "R4 hv identifiers" : "R5 guest identifiers",
            {rsp_lpid, 12'd0, rsp_pid}, {ex_l, 12'd0, ex_p});
        chk(fault_dar == exp_dar, "R8 dar held", fault_dar, exp_dar);
      end
      chk(rsp_quadrant == q, "R10 quadrant", {62'd0, rsp_quadrant}, {62'd0, q});
      @(negedge clk);
      chk(rsp_valid == 0 && rsp_fault == 0, "R2 no request no strobe",
          {62'd0, rsp_valid, rsp_fault}, 0);
      chk(fault_dar == exp_dar, "R8 dar idle hold", fault_dar, exp_dar);
    end
    rst = 1'b1;
    @(negedge clk);
    chk(fault_dar == 0 && seg_data == 0, "R1 re-reset", fault_dar, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule